// File: doc/BRIEF.md
# Receive Data Block Quadlet Demultiplexer

This block sits behind the packet parser of an isochronous audio receiver. It takes the payload one 32-bit quadlet at a time. Each data block begins with a quadlet that carries a start marker. The block drops a programmable number of leading quadlets. It hands each following quadlet to the next audio channel index in turn. After the audio quadlets it hands on at most one MIDI quadlet, and only when the stream has at least one MIDI port. Anything else in the block is thrown away until the next start marker arrives.

Configuration is sampled when a data block starts, so writes that land in the middle of a block never tear it. The configuration covers the leading skip, the audio channel count, the MIDI port count, the channel number, the enable and the byte order. A stream is silent when it is disabled or when its channel number is all ones, which is the encoding for -1, "unused". The one exception is the per-channel label mask. It is read live, so it may change while the stream runs. A start marker that arrives before the previous block was complete produces a one-cycle error strobe.

Top module: `rx_quadlet_demux`

## Requirements
- R1: While reset is held and in the cycle after it is released, `aud_valid_o`, `midi_valid_o` and `short_err_o` are 0.
- R2: The index counts quadlets within a block; the quadlet carrying the start marker has index 0. Quadlets with index below the skip count give no output.
- R3: The quadlet at index skip+i, for i below the audio count, raises `aud_valid_o` one cycle after it is accepted, with `aud_chan_o` = i. The audio count is clamped to MAX_CH (32 by default).
- R4: When the MIDI port count is nonzero (legal range 0 to 8), the quadlet at index skip+audio_count raises `midi_valid_o` one cycle later and carries that quadlet. When the count is 0, no MIDI strobe is ever raised.
- R5: Quadlets that arrive before the first start marker after reset give no output. So do quadlets past the last audio or MIDI position of a block.
- R6: A block that starts while `enable_i` is 0, or while `iso_chan_i` is all ones (-1, unused), gives no audio or MIDI output.
- R7: With the block's swap setting at 1, the output word is the input with its bytes reversed: input bits [7:0] go to output [31:24], and so on. With the setting at 0, the word passes unchanged.
- R8: `aud_label_o` equals bit `aud_chan_o` of `label_mask_i` as it stood in the cycle the quadlet was accepted.
- R9: A valid start marker raises `short_err_o` for one cycle, one cycle later, when an earlier block had started and had taken fewer quadlets than its skip+audio+MIDI length. The marker quadlet still begins the new block at index 0.
- R10: Skip, audio count, MIDI count, swap, enable and channel number are captured from the start-marker quadlet's cycle. Changes to them later in the block have no effect on that block.
- R11: A cycle with `q_valid_i` at 0 gives no output in the next cycle and does not advance the index.
- R12: `aud_valid_o` and `midi_valid_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Stream run enable, sampled at block start |
| iso_chan_i | input | ISO_W | Channel number; all ones means unused |
| skip_i | input | SKIP_W | Leading quadlets to drop per block |
| audio_cnt_i | input | ACNT_W | Audio channels per block (clamped to MAX_CH) |
| midi_cnt_i | input | MIDI_W | MIDI ports; nonzero adds one quadlet |
| swap_i | input | 1 | Reverse byte order of each quadlet |
| label_mask_i | input | MAX_CH | Per-channel label flag, read live |
| q_valid_i | input | 1 | Quadlet present this cycle |
| q_sob_i | input | 1 | Quadlet is the first of a data block |
| q_data_i | input | 32 | Quadlet payload |
| aud_valid_o | output | 1 | Audio sample strobe |
| aud_chan_o | output | CH_W | Audio channel index |
| aud_data_o | output | 32 | Audio sample |
| aud_label_o | output | 1 | Label flag of this channel |
| midi_valid_o | output | 1 | MIDI quadlet strobe |
| midi_data_o | output | 32 | MIDI quadlet |
| short_err_o | output | 1 | Block cut short by a new start marker |

## Verification
The bench aims at the boundaries inside a block. These are index skip-1 against skip, the last audio index against the MIDI slot, and the MIDI slot against the trailing drop region. An off-by-one in the router shows up there as a shifted channel index, a lost or doubled MIDI strobe, or a trailing quadlet leaking out as audio. Configuration writes in mid-block and a start marker arriving early are driven on purpose. A design that read the configuration live would re-route the rest of the block. A design that missed the early marker would stay silent on `short_err_o`, or would keep counting from the old index. Idle gaps, quadlets before the first marker, unused and disabled streams, byte swapping, clamping of oversized audio counts and mask flips in mid-block complete the set.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  typedef enum logic [1:0] {
    QK_DROP  = 2'd0,
    QK_AUDIO = 2'd1,
    QK_MIDI  = 2'd2
  } qkind_e;

  // Audio count limited to what the output index can name
  function automatic int clamp_count(int req, int limit);
    return (req > limit) ? limit : req;
  endfunction

  // Quadlets a complete block consumes
  function automatic int block_len(int skip, int acnt, bit has_midi);
    return skip + acnt + (has_midi ? 1 : 0);
  endfunction

  // Role of quadlet k inside its block
  function automatic qkind_e quad_kind(int k, int skip, int acnt, bit has_midi);
    if (k < skip)                         return QK_DROP;
    else if (k < skip + acnt)             return QK_AUDIO;
    else if (has_midi && k == skip + acnt) return QK_MIDI;
    else                                  return QK_DROP;
  endfunction

  function automatic logic [31:0] order_bytes(logic [31:0] d, logic swap);
    return swap ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

endpackage

// File: rtl/rxq_cfg_shadow.sv
`timescale 1ns/1ps
module rxq_cfg_shadow import rxq_pkg::*; #(
  parameter int SKIP_W = 8,
  parameter int ACNT_W = 8,
  parameter int CNT_W  = 6,
  parameter int MIDI_W = 4,
  parameter int ISO_W  = 8,
  parameter int MAX_CH = 32,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [ACNT_W-1:0] acnt_i,
  input  logic [MIDI_W-1:0] midi_i,
  input  logic [ISO_W-1:0]  iso_i,
  input  logic              enable_i,
  input  logic              swap_i,
  output logic [SKIP_W-1:0] eff_skip_o,
  output logic [CNT_W-1:0]  eff_acnt_o,
  output logic              eff_midi_o,
  output logic              eff_swap_o,
  output logic              eff_active_o,
  output logic [IDX_W-1:0]  cur_len_o
);

  logic [CNT_W-1:0]  live_acnt;
  logic              live_midi, live_active;
  logic [SKIP_W-1:0] sh_skip;
  logic [CNT_W-1:0]  sh_acnt;
  logic              sh_midi, sh_swap, sh_active;

  assign live_acnt   = CNT_W'(clamp_count(int'(acnt_i), MAX_CH));
  assign live_midi   = |midi_i;
  assign live_active = enable_i && (iso_i != '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_skip   <= '0;
      sh_acnt   <= '0;
      sh_midi   <= 1'b0;
      sh_swap   <= 1'b0;
      sh_active <= 1'b0;
    end else if (load_i) begin
      sh_skip   <= skip_i;
      sh_acnt   <= live_acnt;
      sh_midi   <= live_midi;
      sh_swap   <= swap_i;
      sh_active <= live_active;
    end
  end

  // The block-start quadlet itself already uses the new settings
  always_comb begin
    if (load_i) begin
      eff_skip_o   = skip_i;
      eff_acnt_o   = live_acnt;
      eff_midi_o   = live_midi;
      eff_swap_o   = swap_i;
      eff_active_o = live_active;
    end else begin
      eff_skip_o   = sh_skip;
      eff_acnt_o   = sh_acnt;
      eff_midi_o   = sh_midi;
      eff_swap_o   = sh_swap;
      eff_active_o = sh_active;
    end
  end

  assign cur_len_o = IDX_W'(block_len(int'(sh_skip), int'(sh_acnt), sh_midi));

endmodule

// File: rtl/rxq_position.sv
`timescale 1ns/1ps
module rxq_position #(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             sob_i,
  input  logic [IDX_W-1:0] cur_len_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             started_o,
  output logic             short_o
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  logic [IDX_W-1:0] idx_q;
  logic             started_q;

  assign idx_o     = sob_i ? '0 : idx_q;
  assign started_o = sob_i | started_q;
  assign short_o   = valid_i && sob_i && started_q && (idx_q < cur_len_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      started_q <= 1'b0;
    end else if (valid_i) begin
      if (started_o)
        idx_q <= (idx_o == IDX_MAX) ? IDX_MAX : idx_o + 1'b1;
      if (sob_i)
        started_q <= 1'b1;
    end
  end

endmodule

// File: rtl/rxq_router.sv
`timescale 1ns/1ps
module rxq_router import rxq_pkg::*; #(
  parameter int SKIP_W = 8,
  parameter int CNT_W  = 6,
  parameter int IDX_W  = 9,
  parameter int MAX_CH = 32,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              started_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [CNT_W-1:0]  acnt_i,
  input  logic              midi_i,
  input  logic              swap_i,
  input  logic              active_i,
  input  logic              short_i,
  input  logic [MAX_CH-1:0] label_mask_i,
  input  logic [31:0]       data_i,
  output logic              aud_fire_o,
  output logic              midi_fire_o,
  output logic              aud_valid_o,
  output logic [CH_W-1:0]   aud_chan_o,
  output logic [31:0]       aud_data_o,
  output logic              aud_label_o,
  output logic              midi_valid_o,
  output logic [31:0]       midi_data_o,
  output logic              short_err_o
);

  qkind_e      kind;
  logic        take;
  logic [CH_W-1:0] chan;
  logic [31:0] word;

  assign kind        = quad_kind(int'(idx_i), int'(skip_i), int'(acnt_i), midi_i);
  assign take        = valid_i && started_i && active_i;
  assign chan        = CH_W'(int'(idx_i) - int'(skip_i));
  assign word        = order_bytes(data_i, swap_i);
  assign aud_fire_o  = take && (kind == QK_AUDIO);
  assign midi_fire_o = take && (kind == QK_MIDI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aud_valid_o  <= 1'b0;
      aud_chan_o   <= '0;
      aud_data_o   <= '0;
      aud_label_o  <= 1'b0;
      midi_valid_o <= 1'b0;
      midi_data_o  <= '0;
      short_err_o  <= 1'b0;
    end else begin
      aud_valid_o  <= aud_fire_o;
      midi_valid_o <= midi_fire_o;
      short_err_o  <= short_i;
      if (aud_fire_o) begin
        aud_chan_o  <= chan;
        aud_data_o  <= word;
        aud_label_o <= label_mask_i[chan];
      end
      if (midi_fire_o)
        midi_data_o <= word;
    end
  end

endmodule

// File: rtl/rx_quadlet_demux.sv
`timescale 1ns/1ps
module rx_quadlet_demux #(
  parameter int MAX_CH = 32,
  parameter int SKIP_W = 8,
  parameter int ACNT_W = 8,
  parameter int MIDI_W = 4,
  parameter int ISO_W  = 8,
  localparam int CH_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic [ISO_W-1:0]  iso_chan_i,
  input  logic [SKIP_W-1:0] skip_i,
  input  logic [ACNT_W-1:0] audio_cnt_i,
  input  logic [MIDI_W-1:0] midi_cnt_i,
  input  logic              swap_i,
  input  logic [MAX_CH-1:0] label_mask_i,
  input  logic              q_valid_i,
  input  logic              q_sob_i,
  input  logic [31:0]       q_data_i,
  output logic              aud_valid_o,
  output logic [CH_W-1:0]   aud_chan_o,
  output logic [31:0]       aud_data_o,
  output logic              aud_label_o,
  output logic              midi_valid_o,
  output logic [31:0]       midi_data_o,
  output logic              short_err_o
);

  localparam int CNT_W = $clog2(MAX_CH + 1);
  localparam int IDX_W = $clog2((1 << SKIP_W) + MAX_CH + 2);

  // Named internal events
  logic              blk_start_w;
  logic              started_w;
  logic              short_w;
  logic              aud_fire_w;
  logic              midi_fire_w;
  logic [IDX_W-1:0]  idx_w;
  logic [IDX_W-1:0]  len_w;
  logic [SKIP_W-1:0] eff_skip_w;
  logic [CNT_W-1:0]  eff_acnt_w;
  logic              eff_midi_w, eff_swap_w, eff_active_w;

  assign blk_start_w = q_valid_i && q_sob_i;

  rxq_cfg_shadow #(
    .SKIP_W(SKIP_W), .ACNT_W(ACNT_W), .CNT_W(CNT_W), .MIDI_W(MIDI_W),
    .ISO_W(ISO_W), .MAX_CH(MAX_CH), .IDX_W(IDX_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(blk_start_w),
    .skip_i(skip_i), .acnt_i(audio_cnt_i), .midi_i(midi_cnt_i),
    .iso_i(iso_chan_i), .enable_i(enable_i), .swap_i(swap_i),
    .eff_skip_o(eff_skip_w), .eff_acnt_o(eff_acnt_w), .eff_midi_o(eff_midi_w),
    .eff_swap_o(eff_swap_w), .eff_active_o(eff_active_w), .cur_len_o(len_w)
  );

  rxq_position #(.IDX_W(IDX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .valid_i(q_valid_i), .sob_i(q_sob_i),
    .cur_len_i(len_w), .idx_o(idx_w), .started_o(started_w), .short_o(short_w)
  );

  rxq_router #(
    .SKIP_W(SKIP_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .MAX_CH(MAX_CH), .CH_W(CH_W)
  ) u_route (
    .clk(clk), .rst_n(rst_n), .valid_i(q_valid_i), .started_i(started_w),
    .idx_i(idx_w), .skip_i(eff_skip_w), .acnt_i(eff_acnt_w), .midi_i(eff_midi_w),
    .swap_i(eff_swap_w), .active_i(eff_active_w), .short_i(short_w),
    .label_mask_i(label_mask_i), .data_i(q_data_i),
    .aud_fire_o(aud_fire_w), .midi_fire_o(midi_fire_w),
    .aud_valid_o(aud_valid_o), .aud_chan_o(aud_chan_o), .aud_data_o(aud_data_o),
    .aud_label_o(aud_label_o), .midi_valid_o(midi_valid_o),
    .midi_data_o(midi_data_o), .short_err_o(short_err_o)
  );

endmodule

// File: rtl/rxq_checker.sv
`timescale 1ns/1ps
module rxq_checker #(
  parameter int MAX_CH = 32,
  parameter int CH_W   = 5,
  parameter int ISO_W  = 8,
  parameter int SKIP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              q_valid_i,
  input logic [ISO_W-1:0]  iso_chan_i,
  input logic [SKIP_W-1:0] skip_i,
  input logic [MAX_CH-1:0] label_mask_i,
  input logic              aud_valid_o,
  input logic [CH_W-1:0]   aud_chan_o,
  input logic              aud_label_o,
  input logic              midi_valid_o,
  input logic              short_err_o,
  input logic              blk_start_w,
  input logic              started_w
);

  logic [MAX_CH-1:0] mask_d;
  always_ff @(posedge clk) mask_d <= label_mask_i;

  a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(aud_valid_o && midi_valid_o));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid_i |=> !aud_valid_o && !midi_valid_o && !short_err_o);

  a_r6_unused_block: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_w && (iso_chan_i == '1) |=> !aud_valid_o && !midi_valid_o);

  a_r2_skip_first: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start_w && (skip_i != '0) |=> !aud_valid_o && !midi_valid_o);

  a_r5_no_start_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    !started_w |=> !aud_valid_o && !midi_valid_o);

  a_r9_err_on_marker: assert property (@(posedge clk) disable iff (!rst_n)
    short_err_o |-> $past(blk_start_w));

  a_r8_label_follows_mask: assert property (@(posedge clk) disable iff (!rst_n)
    aud_valid_o |-> aud_label_o == mask_d[aud_chan_o]);

endmodule

bind rx_quadlet_demux rxq_checker #(
  .MAX_CH(MAX_CH), .CH_W(CH_W), .ISO_W(ISO_W), .SKIP_W(SKIP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid_i(q_valid_i), .iso_chan_i(iso_chan_i),
  .skip_i(skip_i), .label_mask_i(label_mask_i), .aud_valid_o(aud_valid_o),
  .aud_chan_o(aud_chan_o), .aud_label_o(aud_label_o),
  .midi_valid_o(midi_valid_o), .short_err_o(short_err_o),
  .blk_start_w(blk_start_w), .started_w(started_w)
);

// File: tb/sim_rx_quadlet_demux.sv
`timescale 1ns/1ps
module sim_rx_quadlet_demux;
  localparam int MAXC = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        c_en = 1'b0, c_swap = 1'b0;
  logic [7:0]  c_iso = 8'd0, c_skip = 8'd0, c_acnt = 8'd0;
  logic [3:0]  c_midi = 4'd0;
  logic [31:0] c_mask = 32'd0;
  logic        q_valid = 1'b0, q_sob = 1'b0;
  logic [31:0] q_data = 32'd0;

  logic        aud_valid, aud_label, midi_valid, short_err;
  logic [4:0]  aud_chan;
  logic [31:0] aud_data, midi_data;

  rx_quadlet_demux u0 (
    .clk(clk), .rst_n(rst_n), .enable_i(c_en), .iso_chan_i(c_iso),
    .skip_i(c_skip), .audio_cnt_i(c_acnt), .midi_cnt_i(c_midi), .swap_i(c_swap),
    .label_mask_i(c_mask), .q_valid_i(q_valid), .q_sob_i(q_sob), .q_data_i(q_data),
    .aud_valid_o(aud_valid), .aud_chan_o(aud_chan), .aud_data_o(aud_data),
    .aud_label_o(aud_label), .midi_valid_o(midi_valid), .midi_data_o(midi_data),
    .short_err_o(short_err)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  string ctx = "";

  // Bench model state
  bit m_started = 0;
  int m_idx = 0;
  int sh_skip = 0, sh_acnt = 0, sh_len = 0;
  bit sh_midi = 0, sh_swap = 0, sh_act = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s%s actual=%h expected=%h", tag, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(logic [31:0] d, bit sw);
    logic [31:0] r;
    r = {<<8{d}};
    return sw ? r : d;
  endfunction

  task automatic step(input logic v, input logic s, input logic [31:0] d);
    bit e_aud = 0, e_midi = 0, e_err = 0, e_lab = 0;
    int e_ch = 0;
    logic [31:0] e_word = '0;
    string why_a, why_m;
    why_a = "R11"; why_m = "R11";
    q_valid = v; q_sob = s; q_data = d;
    if (v) begin
      why_a = "R5"; why_m = "R5";
      if (s) begin
        e_err   = m_started && (m_idx < sh_len);
        sh_skip = c_skip;
        sh_acnt = (c_acnt > MAXC) ? MAXC : c_acnt;
        sh_midi = (c_midi != 0);
        sh_swap = c_swap;
        sh_act  = c_en && (c_iso != 8'hFF);
        sh_len  = sh_skip + sh_acnt + (sh_midi ? 1 : 0);
        m_started = 1;
        m_idx = 0;
      end
      if (m_started) begin
        int k;
        k = m_idx;
        m_idx++;
        e_word = expect_word(d, sh_swap);
        if (!sh_act) begin why_a = "R6"; why_m = "R6"; end
        else if (k < sh_skip) begin why_a = "R2"; why_m = "R2"; end
        else if (k - sh_skip < sh_acnt) begin
          e_aud = 1; e_ch = k - sh_skip; e_lab = c_mask[e_ch]; why_m = "R4";
        end else if (k - sh_skip == sh_acnt && sh_midi) begin
          e_midi = 1; why_a = "R4";
        end else if (k - sh_skip == sh_acnt) begin
          why_m = "R4";
        end
      end
    end
    @(negedge clk);
    chk("R12", {31'd0, aud_valid && midi_valid}, 32'd0);
    chk("R9", {31'd0, short_err}, {31'd0, e_err});
    if (e_aud) begin
      chk("R3 valid", {31'd0, aud_valid}, 32'd1);
      chk("R3 chan", {27'd0, aud_chan}, e_ch);
      chk(sh_swap ? "R7 data" : "R3 data", aud_data, e_word);
      chk("R8 label", {31'd0, aud_label}, {31'd0, e_lab});
    end else chk(why_a, {31'd0, aud_valid}, 32'd0);
    if (e_midi) begin
      chk("R4 valid", {31'd0, midi_valid}, 32'd1);
      chk(sh_swap ? "R7 midi" : "R4 midi", midi_data, e_word);
    end else chk(why_m, {31'd0, midi_valid}, 32'd0);
    q_valid = 1'b0; q_sob = 1'b0;
  endtask

  task automatic set_cfg(input int sk, input int ac, input int mi, input bit en,
                         input logic [7:0] iso, input bit sw);
    c_skip = 8'(sk); c_acnt = 8'(ac); c_midi = 4'(mi);
    c_en = en; c_iso = iso; c_swap = sw;
  endtask

  // Sends a block of n quadlets, first with the start marker
  task automatic send_block(input int n, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps && ($urandom % 4 == 0)) step(1'b0, 1'b0, $urandom);
      step(1'b1, i == 0, $urandom);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", {29'd0, aud_valid, midi_valid, short_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {29'd0, aud_valid, midi_valid, short_err}, 32'd0);

    // R5: quadlets before any start marker
    set_cfg(0, 4, 1, 1, 8'd3, 0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, $urandom);

    // R3/R4 plain block, then R2 skip with trailing drop
    c_mask = 32'hA5A5_0F0F;
    send_block(5, 0);
    set_cfg(3, 4, 2, 1, 8'd7, 0);
    send_block(11, 1);
    // R4 with no MIDI ports
    set_cfg(1, 3, 0, 1, 8'd0, 0);
    send_block(6, 0);
    // R7 swap, R3 clamp of oversized count
    set_cfg(0, 40, 8, 1, 8'd63, 1);
    send_block(35, 0);
    // R6 unused channel and disabled stream
    set_cfg(0, 3, 1, 1, 8'hFF, 0);
    send_block(4, 0);
    set_cfg(0, 3, 1, 0, 8'd2, 0);
    send_block(4, 0);
    // R9 short block
    set_cfg(2, 4, 1, 1, 8'd5, 0);
    send_block(3, 0);
    send_block(7, 0);
    // R10 configuration written mid-block
    ctx = " (R10)";
    set_cfg(1, 2, 1, 1, 8'd9, 0);
    step(1'b1, 1'b1, $urandom);
    set_cfg(5, 0, 0, 0, 8'hFF, 1);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, $urandom);
    ctx = "";

    // Random blocks, mask changes and config churn
    for (int b = 0; b < 400; b++) begin
      int len, n;
      set_cfg(($urandom % 6 == 0) ? $urandom % 20 : $urandom % 4,
              ($urandom % 8 == 0) ? $urandom % 40 : $urandom % 9,
              $urandom % 9, ($urandom % 8) != 0,
              ($urandom % 8 == 0) ? 8'hFF : 8'($urandom % 64), $urandom % 2);
      len = c_skip + ((c_acnt > MAXC) ? MAXC : c_acnt) + ((c_midi != 0) ? 1 : 0);
      n = len + int'($urandom % 5) - 2;
      if (n < 1) n = 1;
      for (int i = 0; i < n; i++) begin
        if ($urandom % 5 == 0) step(1'b0, 1'b0, $urandom);
        if ($urandom % 3 == 0) c_mask = $urandom;
        if (i == 1 && $urandom % 4 == 0) c_skip = 8'($urandom % 10);
        step(1'b1, i == 0, $urandom);
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule